// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable integer ratio and produces one single-cycle feedback pulse per division period. The ratio is formed as N = P*B + A. P is the modulus of a dual-modulus prescaler. The prescaler divides by P or by P+1 and is built from a divide-by-4/5 core followed by divide-by-2 stages. B is the preset of a main counter, and A is the preset of a swallow counter. Both counters advance once per prescaler output period. While the swallow count is nonzero, the prescaler runs at P+1. After it reaches zero, the prescaler runs at P for the rest of the period.

The select code, the main preset and the swallow preset are sampled only at a division boundary, which is the clock edge that raises the feedback pulse. A period already under way therefore always completes with the values it started with. Settings that break the ratio rules are repaired where possible. Any such setting also raises a sticky error flag, which only reset clears.

Top module: `pulse_swallow_divider`

## Requirements
- R1: For legal settings, consecutive rising edges of `fb_pulse` are exactly P*B + A input clocks apart, and `cfg_err` stays 0.
- R2: `pre_sel` selects the prescaler modulus: code 0 gives P=8, 1 gives 16, 2 gives 32 and 3 gives 64.
- R3: Each prescaler period lasts P+1 input clocks while the swallow count is nonzero and P clocks otherwise, so with A=0 the ratio is exactly P*B.
- R4: `fb_pulse` is high for exactly one input clock per division period.
- R5: If the sampled A exceeds the effective B, A is replaced by B, so N = (P+1)*B, and `cfg_err` is set.
- R6: If the sampled B is below 3, B is treated as 3 and `cfg_err` is set.
- R7: If the resulting N is below P*P − P, the division still runs at N but `cfg_err` is set; N equal to P*P − P is legal.
- R8: Once set, `cfg_err` stays 1 until reset, even when later settings are legal.
- R9: Changes to `pre_sel`, `main_preset` or `swallow_preset` during a period do not alter that period; they take effect from the next boundary.
- R10: While `rst_n` is low, at the next clock edge `fb_pulse` and `cfg_err` go to 0. After `rst_n` is released, the first `fb_pulse` appears on the (N+1)-th input clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_sel | input | 2 | Prescaler modulus select code |
| main_preset | input | 13 | Main counter preset B |
| swallow_preset | input | 6 | Swallow counter preset A |
| fb_pulse | output | 1 | One-clock pulse once every N input clocks |
| cfg_err | output | 1 | Sticky flag for an illegal or repaired setting |

## Verification
A wrong prescaler modulus or a miscounted swallow phase shows up as a change in the spacing of `fb_pulse` within one division period. Single-clock errors are exposed by comparing that spacing with P*B + A for several select codes and swallow values, including A=0 and A=B. A faulty boundary capture shows up in the period right after an input change, as the old or the new ratio appearing one period too early or too late. Errors in the repair or error logic appear on `cfg_err` one clock after the boundary, and also as a ratio that differs from the repaired value.

// File: rtl/pswallow_pkg.sv
// Package: shared constants and helpers for the pulse-swallow divider.
// Assumes a 2-bit modulus select where code k gives P = 8 << k.
package pswallow_pkg;
    localparam int SEL_W   = 2;
    localparam int STAGE_W = 4;   // enough for 2^(SEL_W^2) divide-by-2 passes
    localparam int CORE_W  = 3;   // holds 0..4 for the 4/5 core
    localparam int PMOD_W  = 8;   // holds P+1 up to 65

    // Returns the prescaler low modulus P for a select code.
    function automatic logic [PMOD_W-1:0] low_modulus(input logic [SEL_W-1:0] sel);
        return PMOD_W'(8) << sel;
    endfunction
endpackage

// File: rtl/pswallow_prescaler.sv
// Module: dual-modulus prescaler, a 4/5 core followed by divide-by-2 passes.
// The core divides by 5 on the last pass of a period when mod_hi is set,
// giving P+1; otherwise P = 4 * 2^(sel+1). tick marks the last input clock
// of a prescaler period. restart returns the prescaler to the period start.
module pswallow_prescaler
    import pswallow_pkg::*;
(
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    input  logic             mod_hi,
    output logic             tick
);
    logic [CORE_W-1:0]  core_q;
    logic [STAGE_W-1:0] stage_q;
    logic [STAGE_W-1:0] stage_last;
    logic [CORE_W-1:0]  core_last;
    logic               last_pass;

    // Decode the final pass index and the core length of the current pass.
    always_comb begin
        stage_last = STAGE_W'((5'd2 << sel) - 5'd1);
        last_pass  = (stage_q == stage_last);
        core_last  = (mod_hi && last_pass) ? CORE_W'(4) : CORE_W'(3);
        tick       = (core_q == core_last) && last_pass;
    end

    // Advance the core and the pass counter, wrapping at the period end.
    always_ff @(posedge clk_in) begin
        if (!rst_n || restart) begin
            core_q  <= '0;
            stage_q <= '0;
        end else if (core_q == core_last) begin
            core_q  <= '0;
            stage_q <= tick ? '0 : stage_q + STAGE_W'(1);
        end else begin
            core_q  <= core_q + CORE_W'(1);
        end
    end
endmodule

// File: rtl/pswallow_counters.sv
// Module: main and swallow counters, stepped once per prescaler period.
// Assumes a_load <= b_load and b_load >= 1 when load is asserted. The swallow
// count holds at zero; the main count reaching one marks the final period.
module pswallow_counters #(
    parameter int B_W = 13,
    parameter int A_W = 6
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic           load,
    input  logic           tick,
    input  logic [B_W-1:0] b_load,
    input  logic [A_W-1:0] a_load,
    output logic [B_W-1:0] main_q,
    output logic [A_W-1:0] swallow_q,
    output logic           mod_hi,
    output logic           final_period
);
    // Flag the swallow phase and the last prescaler period of the division.
    always_comb begin
        mod_hi       = (swallow_q != '0);
        final_period = (main_q == B_W'(1));
    end

    // Load presets at a boundary; otherwise count down once per period.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            main_q    <= '0;
            swallow_q <= '0;
        end else if (load) begin
            main_q    <= b_load;
            swallow_q <= a_load;
        end else if (tick) begin
            main_q <= main_q - B_W'(1);
            if (swallow_q != '0) begin
                swallow_q <= swallow_q - A_W'(1);
            end
        end
    end
endmodule

// File: rtl/pswallow_cfg.sv
// Module: boundary capture and repair of the divider settings.
// Raises B to B_MIN, limits A to B, and flags any repair or a ratio below
// the contiguity floor P*P - P. The flag is sticky until reset.
module pswallow_cfg
    import pswallow_pkg::*;
#(
    parameter int B_W   = 13,
    parameter int A_W   = 6,
    parameter int B_MIN = 3
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [B_W-1:0]   b_in,
    input  logic [A_W-1:0]   a_in,
    output logic [SEL_W-1:0] sel_q,
    output logic [B_W-1:0]   b_fix,
    output logic [A_W-1:0]   a_fix,
    output logic             err_q
);
    localparam int RATIO_W = B_W + PMOD_W;

    logic               b_low;
    logic               a_high;
    logic [RATIO_W-1:0] p_val;
    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] floor_val;
    logic               bad;

    // Repair the presets and test the ratio rules.
    always_comb begin
        b_low     = (b_in < B_W'(B_MIN));
        b_fix     = b_low ? B_W'(B_MIN) : b_in;
        a_high    = (B_W'(a_in) > b_fix);
        a_fix     = a_high ? A_W'(b_fix) : a_in;
        p_val     = RATIO_W'(low_modulus(sel_in));
        ratio     = RATIO_W'(b_fix) * p_val + RATIO_W'(a_fix);
        floor_val = p_val * p_val - p_val;
        bad       = b_low || a_high || (ratio < floor_val);
    end

    // Hold the active select code and accumulate the sticky error.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            sel_q <= '0;
            err_q <= 1'b0;
        end else if (load) begin
            sel_q <= sel_in;
            if (bad) begin
                err_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pulse_swallow_divider.sv
// Module: top level of the pulse-swallow divider, N = P*B + A.
// A priming cycle after reset performs the first capture; afterwards each
// final prescaler tick is a boundary that captures settings and pulses.
module pulse_swallow_divider #(
    parameter int B_W   = 13,
    parameter int A_W   = 6,
    parameter int B_MIN = 3
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic [1:0]     pre_sel,
    input  logic [B_W-1:0] main_preset,
    input  logic [A_W-1:0] swallow_preset,
    output logic           fb_pulse,
    output logic           cfg_err
);
    logic           prime_q;
    logic           pre_tick;
    logic           mod_hi;
    logic           final_period;
    logic           load;
    logic [1:0]     sel_q;
    logic [B_W-1:0] b_fix;
    logic [A_W-1:0] a_fix;
    logic [B_W-1:0] main_q;
    logic [A_W-1:0] swallow_q;

    // A boundary is the priming cycle or the last tick of a division.
    always_comb load = prime_q || (pre_tick && final_period);

    // Priming flag and registered feedback pulse.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            prime_q  <= 1'b1;
            fb_pulse <= 1'b0;
        end else begin
            prime_q  <= 1'b0;
            fb_pulse <= pre_tick && final_period;
        end
    end

    pswallow_cfg #(.B_W(B_W), .A_W(A_W), .B_MIN(B_MIN)) u_cfg (
        .clk_in (clk_in),
        .rst_n  (rst_n),
        .load   (load),
        .sel_in (pre_sel),
        .b_in   (main_preset),
        .a_in   (swallow_preset),
        .sel_q  (sel_q),
        .b_fix  (b_fix),
        .a_fix  (a_fix),
        .err_q  (cfg_err)
    );

    pswallow_prescaler u_pre (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .restart (load),
        .sel     (sel_q),
        .mod_hi  (mod_hi),
        .tick    (pre_tick)
    );

    pswallow_counters #(.B_W(B_W), .A_W(A_W)) u_cnt (
        .clk_in       (clk_in),
        .rst_n        (rst_n),
        .load         (load),
        .tick         (pre_tick),
        .b_load       (b_fix),
        .a_load       (a_fix),
        .main_q       (main_q),
        .swallow_q    (swallow_q),
        .mod_hi       (mod_hi),
        .final_period (final_period)
    );
endmodule

// File: rtl/pswallow_checker.sv
// Module: assertion checker for the pulse-swallow divider, bound to the top.
// Measures prescaler periods with its own counter.
module pswallow_checker
    import pswallow_pkg::*;
#(
    parameter int B_W = 13,
    parameter int A_W = 6
) (
    input logic             clk_in,
    input logic             rst_n,
    input logic             fb_pulse,
    input logic             cfg_err,
    input logic             pre_tick,
    input logic             load,
    input logic [SEL_W-1:0] sel_q,
    input logic [B_W-1:0]   main_q,
    input logic [A_W-1:0]   swallow_q
);
    logic [PMOD_W-1:0] per_cnt;
    logic [PMOD_W-1:0] p_now;

    always_comb p_now = low_modulus(sel_q);

    // Count input clocks since the last prescaler period start.
    always_ff @(posedge clk_in) begin
        if (!rst_n || load || pre_tick) per_cnt <= PMOD_W'(1);
        else                            per_cnt <= per_cnt + PMOD_W'(1);
    end

    assert_pulse_width_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    assert_err_sticky_R8: assert property (@(posedge clk_in) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    assert_swallow_bound_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
        B_W'(swallow_q) <= main_q);

    assert_period_len_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
        pre_tick |-> (per_cnt == p_now) || (per_cnt == p_now + PMOD_W'(1)));

    assert_swallow_hold_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!pre_tick && !load) |=> $stable(swallow_q));

    assert_pulse_after_tick_R1: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(fb_pulse) |-> $past(pre_tick));
endmodule

bind pulse_swallow_divider pswallow_checker #(.B_W(B_W), .A_W(A_W)) u_chk (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .fb_pulse  (fb_pulse),
    .cfg_err   (cfg_err),
    .pre_tick  (pre_tick),
    .load      (load),
    .sel_q     (sel_q),
    .main_q    (main_q),
    .swallow_q (swallow_q)
);

// File: tb/tb_pulse_swallow_divider.sv
// Bench: directed scenarios for the pulse-swallow divider, one task each.
module tb_pulse_swallow_divider;
    logic        clk_in = 1'b0;
    logic        rst_n  = 1'b0;
    logic [1:0]  pre_sel = '0;
    logic [12:0] main_preset = 13'd7;
    logic [5:0]  swallow_preset = '0;
    logic        fb_pulse;
    logic        cfg_err;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    pulse_swallow_divider dut (
        .clk_in         (clk_in),
        .rst_n          (rst_n),
        .pre_sel        (pre_sel),
        .main_preset    (main_preset),
        .swallow_preset (swallow_preset),
        .fb_pulse       (fb_pulse),
        .cfg_err        (cfg_err)
    );

    always #10 clk_in = ~clk_in;   // 50 MHz

    // Watchdog: a hung run ends as a failure.
    always @(posedge clk_in) begin
        cycles++;
        if (cycles > 195000) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=195000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ratio(input int sel, input int b, input int a);
        return (8 << sel) * b + a;
    endfunction

    task automatic setcfg(input int sel, input int b, input int a);
        pre_sel        = 2'(sel);
        main_preset    = 13'(b);
        swallow_preset = 6'(a);
    endtask

    task automatic apply_reset();
        @(negedge clk_in);
        rst_n = 1'b0;
        repeat (3) @(negedge clk_in);
        rst_n = 1'b1;
    endtask

    task automatic wait_pulse();
        while (!fb_pulse) @(negedge clk_in);
    endtask

    task automatic interval_from_here(output int n);
        n = 0;
        do begin
            @(negedge clk_in);
            n++;
        end while (!fb_pulse);
    endtask

    task automatic measure(output int n);
        wait_pulse();
        interval_from_here(n);
    endtask

    // R10: reset state and latency to the first pulse; R4 pulse width.
    task automatic t_reset();
        int n;
        setcfg(0, 7, 3);
        @(negedge clk_in);
        rst_n = 1'b0;
        repeat (2) @(negedge clk_in);
        check(fb_pulse == 1'b0 && cfg_err == 1'b0, "R10 reset outputs", {fb_pulse, cfg_err}, 0);
        rst_n = 1'b1;
        interval_from_here(n);
        check(n == ratio(0, 7, 3) + 1, "R10 first pulse latency", n, ratio(0, 7, 3) + 1);
        @(negedge clk_in);
        check(fb_pulse == 1'b0, "R4 pulse one clock wide", fb_pulse, 0);
    endtask

    // R2/R3: every select code with A=0 gives exactly P*B.
    task automatic t_select();
        int n;
        for (int s = 0; s < 4; s++) begin
            setcfg(s, (8 << s) - 1 + s, 0);
            apply_reset();
            measure(n);
            check(n == ratio(s, (8 << s) - 1 + s, 0), "R2 select modulus", n,
                  ratio(s, (8 << s) - 1 + s, 0));
        end
    endtask

    // R1/R3: swallow values, including A equal to B.
    task automatic t_swallow();
        int n;
        setcfg(1, 20, 15);
        apply_reset();
        measure(n);
        check(n == 335, "R3 swallow ratio", n, 335);
        setcfg(1, 20, 20);
        apply_reset();
        measure(n);
        check(n == 340, "R1 A equals B ratio", n, 340);
        check(cfg_err == 1'b0, "R1 no error when legal", cfg_err, 0);
    endtask

    // R5: A above B is limited to B and flagged.
    task automatic t_clamp();
        int n;
        setcfg(0, 10, 20);
        apply_reset();
        measure(n);
        check(n == 90, "R5 clamped ratio", n, 90);
        check(cfg_err == 1'b1, "R5 error flag", cfg_err, 1);
    endtask

    // R6: B below 3 is raised to 3 and flagged.
    task automatic t_bmin();
        int n;
        setcfg(0, 1, 0);
        apply_reset();
        measure(n);
        check(n == 24, "R6 minimum B ratio", n, 24);
        check(cfg_err == 1'b1, "R6 error flag", cfg_err, 1);
    endtask

    // R7 floor rule, then R8 stickiness, then R10 reset clears the flag.
    task automatic t_floor_sticky();
        int n;
        setcfg(1, 15, 0);
        apply_reset();
        measure(n);
        check(n == 240 && cfg_err == 1'b0, "R7 ratio at floor is legal", n, 240);
        setcfg(1, 5, 2);
        apply_reset();
        measure(n);
        check(n == 82, "R7 below floor still divides", n, 82);
        check(cfg_err == 1'b1, "R7 below floor flagged", cfg_err, 1);
        setcfg(0, 7, 0);
        interval_from_here(n);
        interval_from_here(n);
        check(n == 56, "R8 legal ratio after error", n, 56);
        check(cfg_err == 1'b1, "R8 flag sticky", cfg_err, 1);
        apply_reset();
        @(negedge clk_in);
        check(cfg_err == 1'b0, "R10 reset clears flag", cfg_err, 0);
    endtask

    // R9: a mid-period change leaves the running period intact.
    task automatic t_midchange();
        int n;
        setcfg(0, 8, 1);
        apply_reset();
        wait_pulse();
        n = 0;
        do begin
            @(negedge clk_in);
            n++;
            if (n == 5) setcfg(1, 16, 3);
        end while (!fb_pulse);
        check(n == 65, "R9 running period unchanged", n, 65);
        interval_from_here(n);
        check(n == 259, "R9 new setting at next boundary", n, 259);
    endtask

    // R1: pseudo-random legal settings changed at boundaries without reset.
    task automatic t_random();
        int n;
        int s;
        int b;
        int a;
        setcfg(0, 7, 0);
        apply_reset();
        wait_pulse();
        for (int i = 0; i < 8; i++) begin
            s = $urandom_range(3, 0);
            b = (8 << s) - 1 + $urandom_range(8, 0);
            a = $urandom_range((b < 63) ? b : 63, 0);
            setcfg(s, b, a);
            interval_from_here(n);
            interval_from_here(n);
            check(n == ratio(s, b, a), "R1 random legal ratio", n, ratio(s, b, a));
            check(cfg_err == 1'b0, "R1 random no error", cfg_err, 0);
        end
    endtask

    initial begin
        t_reset();
        t_select();
        t_swallow();
        t_clamp();
        t_bmin();
        t_floor_sticky();
        t_midchange();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule